// File: doc/BRIEF.md
# Pipelined Single-Precision Square Root Unit

This block takes one IEEE 754 single-precision operand and returns its square root a fixed number of clock cycles later. Along with the operand it receives a 2-bit rounding mode, a guard bit that can cancel the operation's effects, and a query bit. When the query bit is set, the block reports the exception flags but does not write the result. The result comes back with a write-enable strobe and four exception flags: invalid, inexact, input flushed to zero, and output flushed to zero. Denormals are not handled with gradual underflow. A denormal operand is treated as zero, and a denormal result is forced to zero.

The magnitude is found by a restoring digit recurrence. This datapath retires two root bits per clock and keeps one extra bit and a remainder test for rounding. The recurrence is shared and is not fully pipelined. After accepting an operation the unit raises `busy` for a recovery window, and any issue attempt during that window is dropped. The caller keeps the sticky status register, merging the flag pulses into it.

Top module: `fsq_unit`

## Requirements
- R1: For a positive normal operand in mode 00 (nearest, ties to even), the result is the correctly rounded root. Reference vectors: 0x40400000 gives 0x3FDDB3D7, 0x00C00000 gives 0x201CC471, 0x7F7FFFFF gives 0x5F7FFFFF, and each of these raises inexact.
- R2: The rounding mode is encoded as 01 toward zero, 10 toward +infinity and 11 toward -infinity. Each mode rounds the positive root in its own direction, and a carry out of the significand increments the exponent.
- R3: Inexact is raised exactly when the rounded value differs from the true root. An exact root, such as 0x40800000 giving 0x40000000, raises no flag.
- R4: An operand with a zero exponent field and a nonzero fraction is replaced by a zero of the same sign. The result is that signed zero, and input-flush is raised. For example, 0x00400000 gives 0x00000000.
- R5: +0 returns 0x00000000 and -0 returns 0x80000000, and neither raises any flag.
- R6: A negative operand that is not zero and not NaN, including -infinity, returns 0xFFFFFFFF and raises invalid.
- R7: Any NaN operand (exponent 0xFF, fraction nonzero) returns 0xFFFFFFFF. Invalid is raised only when fraction bit 22 is 0, which marks a signalling NaN.
- R8: +infinity (0x7F800000) returns 0x7F800000 and raises no flag.
- R9: An issue accepted on clock edge N produces `flags_valid` and the flag and result outputs visible after edge N+17, held for exactly one cycle. Every flag output is 0 whenever `flags_valid` is 0.
- R10: `busy` is high for the 15 cycles that follow an accepted issue, so the next issue can be accepted 16 edges after the previous one. An issue presented while `busy` is high is dropped and produces no result.
- R11: An operation issued with guard 0 leaves `res_we`, `flags_valid` and all flags low in its result cycle.
- R12: An operation issued with the query bit set raises `flags_valid` and its flags in its result cycle, but keeps `res_we` low.
- R13: A result below the normal range would be replaced by zero with output-flush raised. Because the root of any nonzero normal is at least 2^-63, output-flush never rises for this operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | Issue request, accepted when `busy` is low |
| issue_operand | input | 32 | Single-precision operand |
| issue_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| issue_guard | input | 1 | 1 lets the operation write a result and report flags |
| issue_flags_only | input | 1 | 1 reports flags without a result write |
| busy | output | 1 | Recovery window active, issues are dropped |
| res_we | output | 1 | Result write strobe, one cycle |
| res_data | output | 32 | Result word, updated when `flags_valid` rises |
| flags_valid | output | 1 | Flag report strobe, one cycle |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Rounded result is not exact |
| flag_in_ftz | output | 1 | Denormal operand was flushed to zero |
| flag_out_ftz | output | 1 | Denormal result was flushed to zero |

## Verification
Random positive normals across the whole exponent range, in all four rounding modes, are compared with a bench model. That model computes the integer root by a different method (setting bits and squaring), so errors in the recurrence, in exponent halving for odd and even exponents, and in the rounding direction all show up. Exact squares separate the inexact logic from the sticky remainder. Operands with extreme exponents exercise the exponent arithmetic at both ends. Zeros, denormals of both signs, both kinds of NaN, both infinities and negative normals each take their own special path, so a wrong choice among those paths produces a different word or flag. A closely spaced issue sequence checks that an issue inside the recovery window is dropped, that an issue exactly at the window's end is accepted, and that both accepted results come out on their own cycles.

// File: rtl/fsq_pkg.sv
// Package fsq_pkg: shared widths, types and constants for the square root unit.
// Assumes IEEE 754 single-precision layout (1 sign, 8 exponent, 23 fraction).
package fsq_pkg;

    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;      // significand with hidden one
    localparam int ROOT_W = SIG_W + 2;       // significand + guard + one sticky bit
    localparam int RAD_W  = 2 * ROOT_W;      // radicand bits consumed by the recurrence

    localparam logic [WORD_W-1:0] QNAN_WORD    = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] POS_INF_WORD = 32'h7F80_0000;

    // Rounding direction as driven on the issue port
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
        logic in_ftz;
        logic out_ftz;
    } fsq_flags_t;

    // Operand information carried alongside the recurrence
    typedef struct packed {
        logic                special;
        logic [WORD_W-1:0]   spec_word;
        fsq_flags_t          spec_flags;
        logic                sign;
        logic [EXP_W-1:0]    exp_r;
    } fsq_meta_t;

endpackage

// File: rtl/fsq_unpack.sv
// Module fsq_unpack: classifies the operand, resolves every special case to a
// final word and flags, and prepares the aligned radicand and biased result
// exponent for normal operands. Purely combinational.
// Assumes: denormals flush to a signed zero; any NaN returns the all-ones word.
module fsq_unpack
    import fsq_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output fsq_meta_t         meta,
    output logic [RAD_W-1:0]  radicand
);

    logic               sign;
    logic [EXP_W-1:0]   ex;
    logic [FRAC_W-1:0]  fr;
    logic               exp_zero;
    logic               exp_max;
    logic               frac_zero;
    logic [EXP_W:0]     exp_sum;

    // Field split and classification
    always_comb begin
        sign      = operand[WORD_W-1];
        ex        = operand[WORD_W-2 -: EXP_W];
        fr        = operand[FRAC_W-1:0];
        exp_zero  = (ex == '0);
        exp_max   = (ex == '1);
        frac_zero = (fr == '0);
    end

    // Exponent halving: odd biased exponent means even true exponent
    always_comb begin
        exp_sum  = {1'b0, ex} + (EXP_W+1)'(126) + {{EXP_W{1'b0}}, ex[0]};
        radicand = {1'b1, fr, {(RAD_W-SIG_W){1'b0}}} >> ex[0];
    end

    // Special-case resolution in priority order
    always_comb begin
        meta       = '0;
        meta.sign  = sign;
        meta.exp_r = exp_sum[EXP_W:1];
        if (exp_zero) begin
            meta.special           = 1'b1;
            meta.spec_word         = {sign, {(WORD_W-1){1'b0}}};
            meta.spec_flags.in_ftz = !frac_zero;
        end else if (exp_max && !frac_zero) begin
            meta.special            = 1'b1;
            meta.spec_word          = QNAN_WORD;
            meta.spec_flags.invalid = !fr[FRAC_W-1];
        end else if (sign) begin
            meta.special            = 1'b1;
            meta.spec_word          = QNAN_WORD;
            meta.spec_flags.invalid = 1'b1;
        end else if (exp_max) begin
            meta.special   = 1'b1;
            meta.spec_word = POS_INF_WORD;
        end
    end

endmodule

// File: rtl/fsq_root_core.sv
// Module fsq_root_core: restoring integer square root of a RAD_W-bit radicand,
// STEPS_PER_CYCLE result bits per clock, ROOT_W root bits in total.
// Assumes STEPS_PER_CYCLE divides ROOT_W and that start never arrives while
// an iteration is still running (the caller's recovery window ensures this).
module fsq_root_core
    import fsq_pkg::*;
#(
    parameter int STEPS_PER_CYCLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAD_W-1:0]  rad_in,
    output logic              done,
    output logic [ROOT_W-1:0] root,
    output logic              rem_nz
);

    localparam int ITER_CYCLES = ROOT_W / STEPS_PER_CYCLE;
    localparam int CNT_W       = $clog2(ITER_CYCLES + 1);
    localparam int REM_W       = ROOT_W + 2;

    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [RAD_W-1:0]  rad_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    logic [REM_W-1:0]  rem_c  [STEPS_PER_CYCLE+1];
    logic [ROOT_W-1:0] root_c [STEPS_PER_CYCLE+1];
    logic [RAD_W-1:0]  rad_c  [STEPS_PER_CYCLE+1];

    assign rem_c[0]  = rem_q;
    assign root_c[0] = root_q;
    assign rad_c[0]  = rad_q;

    // One restoring step per generate slice, chained within the clock
    for (genvar s = 0; s < STEPS_PER_CYCLE; s++) begin : g_step
        logic [REM_W-1:0] shifted;
        logic [REM_W-1:0] trial;
        logic [REM_W:0]   diff;
        assign shifted       = {rem_c[s][REM_W-3:0], rad_c[s][RAD_W-1 -: 2]};
        assign trial         = {root_c[s], 2'b01};
        assign diff          = {1'b0, shifted} - {1'b0, trial};
        assign rem_c[s+1]    = diff[REM_W] ? shifted : diff[REM_W-1:0];
        assign root_c[s+1]   = {root_c[s][ROOT_W-2:0], ~diff[REM_W]};
        assign rad_c[s+1]    = {rad_c[s][RAD_W-3:0], 2'b00};
    end

    // Iteration state: load on start, advance while the count is nonzero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            root_q <= '0;
            rad_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            rem_q  <= '0;
            root_q <= '0;
            rad_q  <= rad_in;
            cnt_q  <= CNT_W'(ITER_CYCLES);
        end else if (cnt_q != '0) begin
            rem_q  <= rem_c[STEPS_PER_CYCLE];
            root_q <= root_c[STEPS_PER_CYCLE];
            rad_q  <= rad_c[STEPS_PER_CYCLE];
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Completion pulse in the cycle after the final step
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (cnt_q == CNT_W'(1)) && !start;
    end

    assign done   = done_q;
    assign root   = root_q;
    assign rem_nz = (rem_q != '0);

endmodule

// File: rtl/fsq_round.sv
// Module fsq_round: rounds the root to 24 significand bits in the requested
// direction, adjusts the exponent on carry, flushes an out-of-range result
// and packs the final word and flags. Specials pass through unchanged.
// Assumes root[ROOT_W-1] is set for normal operands (root lies in [1,2)).
module fsq_round
    import fsq_pkg::*;
(
    input  logic [ROOT_W-1:0] root,
    input  logic              rem_nz,
    input  fsq_meta_t         meta,
    input  rmode_e            rm,
    output logic [WORD_W-1:0] word,
    output fsq_flags_t        flags
);

    logic [SIG_W-1:0]  sig;
    logic              guard_b;
    logic              sticky_b;
    logic              inexact;
    logic              up;
    logic [SIG_W:0]    sig_inc;
    logic [EXP_W:0]    exp_adj;

    // Round-bit extraction and direction decision
    always_comb begin
        sig      = root[ROOT_W-1:2];
        guard_b  = root[1];
        sticky_b = root[0] | rem_nz;
        inexact  = guard_b | sticky_b;
        case (rm)
            RM_NEAREST: up = guard_b & (sticky_b | sig[0]);
            RM_ZERO:    up = 1'b0;
            RM_UP:      up = inexact & !meta.sign;
            RM_DOWN:    up = inexact & meta.sign;
            default:    up = 1'b0;
        endcase
    end

    // Increment and exponent carry
    always_comb begin
        sig_inc = {1'b0, sig} + {{SIG_W{1'b0}}, up};
        exp_adj = {1'b0, meta.exp_r} + {{EXP_W{1'b0}}, sig_inc[SIG_W]};
    end

    // Final selection: special, flushed, or packed normal
    always_comb begin
        flags = '0;
        if (meta.special) begin
            word  = meta.spec_word;
            flags = meta.spec_flags;
        end else if (exp_adj == '0) begin
            word          = {meta.sign, {(WORD_W-1){1'b0}}};
            flags.out_ftz = 1'b1;
        end else begin
            word          = {meta.sign, exp_adj[EXP_W-1:0], sig_inc[FRAC_W-1:0]};
            flags.inexact = inexact;
        end
    end

endmodule

// File: rtl/fsq_unit.sv
// Module fsq_unit: single-precision square root with fixed LATENCY and a
// RECOVERY window during which issues are dropped. Unpacks at issue, runs the
// shared recurrence, holds the rounded outcome, and releases it on the
// LATENCY-th edge after issue.
// Assumes LATENCY >= ROOT_W/STEPS_PER_CYCLE + 2 and RECOVERY >
// ROOT_W/STEPS_PER_CYCLE, so one recurrence and one hold slot suffice.
module fsq_unit
    import fsq_pkg::*;
#(
    parameter int LATENCY         = 17,
    parameter int RECOVERY        = 16,
    parameter int STEPS_PER_CYCLE = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_valid,
    input  logic [31:0] issue_operand,
    input  logic [1:0]  issue_rmode,
    input  logic        issue_guard,
    input  logic        issue_flags_only,
    output logic        busy,
    output logic        res_we,
    output logic [31:0] res_data,
    output logic        flags_valid,
    output logic        flag_invalid,
    output logic        flag_inexact,
    output logic        flag_in_ftz,
    output logic        flag_out_ftz
);

    localparam int REC_W = $clog2(RECOVERY + 1);

    logic              accept;
    logic [REC_W-1:0]  rec_q;

    fsq_meta_t         meta_c;
    logic [RAD_W-1:0]  rad_c;
    fsq_meta_t         meta_q;
    rmode_e            rm_q;
    logic              guard_q;
    logic              fonly_q;

    logic              core_done;
    logic [ROOT_W-1:0] core_root;
    logic              core_rem_nz;

    logic [WORD_W-1:0] rnd_word;
    fsq_flags_t        rnd_flags;

    logic [WORD_W-1:0] hold_word;
    fsq_flags_t        hold_flags;
    logic              hold_guard;
    logic              hold_fonly;

    logic [LATENCY-1:0] tag_q;
    fsq_flags_t         out_flags;

    assign accept = issue_valid & ~busy;
    assign busy   = (rec_q != '0);

    // Recovery window counter
    always_ff @(posedge clk) begin
        if (!rst_n)          rec_q <= '0;
        else if (accept)     rec_q <= REC_W'(RECOVERY - 1);
        else if (rec_q != 0) rec_q <= rec_q - 1'b1;
    end

    fsq_unpack u_unpack (
        .operand  (issue_operand),
        .meta     (meta_c),
        .radicand (rad_c)
    );

    // Per-operation context captured at issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            rm_q    <= RM_NEAREST;
            guard_q <= 1'b0;
            fonly_q <= 1'b0;
        end else if (accept) begin
            meta_q  <= meta_c;
            rm_q    <= rmode_e'(issue_rmode);
            guard_q <= issue_guard;
            fonly_q <= issue_flags_only;
        end
    end

    fsq_root_core #(
        .STEPS_PER_CYCLE (STEPS_PER_CYCLE)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .rad_in (rad_c),
        .done   (core_done),
        .root   (core_root),
        .rem_nz (core_rem_nz)
    );

    fsq_round u_round (
        .root   (core_root),
        .rem_nz (core_rem_nz),
        .meta   (meta_q),
        .rm     (rm_q),
        .word   (rnd_word),
        .flags  (rnd_flags)
    );

    // Hold the finished outcome so the recurrence can take the next issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word  <= '0;
            hold_flags <= '0;
            hold_guard <= 1'b0;
            hold_fonly <= 1'b0;
        end else if (core_done) begin
            hold_word  <= rnd_word;
            hold_flags <= rnd_flags;
            hold_guard <= guard_q;
            hold_fonly <= fonly_q;
        end
    end

    // Issue tag delay line that times the release
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= {tag_q[LATENCY-2:0], accept};
    end

    // Output stage: one-cycle strobes, word kept until the next report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_we      <= 1'b0;
            res_data    <= '0;
            flags_valid <= 1'b0;
            out_flags   <= '0;
        end else if (tag_q[LATENCY-1] && hold_guard) begin
            res_we      <= !hold_fonly;
            res_data    <= hold_word;
            flags_valid <= 1'b1;
            out_flags   <= hold_flags;
        end else begin
            res_we      <= 1'b0;
            flags_valid <= 1'b0;
            out_flags   <= '0;
        end
    end

    assign flag_invalid = out_flags.invalid;
    assign flag_inexact = out_flags.inexact;
    assign flag_in_ftz  = out_flags.in_ftz;
    assign flag_out_ftz = out_flags.out_ftz;

endmodule

// File: rtl/fsq_unit_chk.sv
// Module fsq_unit_chk: port-level temporal checks for fsq_unit, bound to it.
// Assumes the same LATENCY and RECOVERY as the bound instance.
module fsq_unit_chk #(
    parameter int LATENCY  = 17,
    parameter int RECOVERY = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic        issue_guard,
    input logic        busy,
    input logic        res_we,
    input logic [31:0] res_data,
    input logic        flags_valid,
    input logic        flag_invalid,
    input logic        flag_inexact,
    input logic        flag_in_ftz,
    input logic        flag_out_ftz
);

    localparam int RC_W = $clog2(RECOVERY + 1);

    logic               acc;
    logic [RC_W-1:0]    since_q;
    logic [LATENCY-1:0] live_q;
    logic [LATENCY-1:0] mute_q;

    assign acc = issue_valid && !busy;

    // Cycles elapsed since the last accepted issue, capped at RECOVERY
    always_ff @(posedge clk) begin
        if (!rst_n)                                   since_q <= '0;
        else if (acc)                                 since_q <= RC_W'(1);
        else if (since_q != 0 && since_q < RECOVERY)  since_q <= since_q + 1'b1;
        else                                          since_q <= '0;
    end

    // Accepted issues split by guard value, delayed to their report cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            mute_q <= '0;
        end else begin
            live_q <= {live_q[LATENCY-2:0], acc && issue_guard};
            mute_q <= {mute_q[LATENCY-2:0], acc && !issue_guard};
        end
    end

    a_r10_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (since_q != 0 && since_q < RECOVERY));

    a_r9_report_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        live_q[LATENCY-1] |=> flags_valid);

    a_r9_no_stray_report: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q[LATENCY-1] |=> !flags_valid);

    a_r9_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_valid |-> !(flag_invalid || flag_inexact || flag_in_ftz || flag_out_ftz));

    a_r11_guard_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q[LATENCY-1] |=> (!flags_valid && !res_we));

    a_r12_write_has_flags: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> flags_valid);

    a_r6_invalid_word: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && flag_invalid) |-> res_data == 32'hFFFF_FFFF);

    a_r13_no_output_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> !flag_out_ftz);

endmodule

bind fsq_unit fsq_unit_chk #(
    .LATENCY  (LATENCY),
    .RECOVERY (RECOVERY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .issue_guard  (issue_guard),
    .busy         (busy),
    .res_we       (res_we),
    .res_data     (res_data),
    .flags_valid  (flags_valid),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .flag_in_ftz  (flag_in_ftz),
    .flag_out_ftz (flag_out_ftz)
);

// File: tb/fsq_unit_test.sv
// Bench for fsq_unit: directed corner cases plus seeded random operands,
// compared with a bench model that finds the root by bit-set-and-square.
module fsq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_operand = '0;
    logic [1:0]  issue_rmode = '0;
    logic        issue_guard = 1'b0;
    logic        issue_flags_only = 1'b0;
    logic        busy;
    logic        res_we;
    logic [31:0] res_data;
    logic        flags_valid;
    logic        flag_invalid;
    logic        flag_inexact;
    logic        flag_in_ftz;
    logic        flag_out_ftz;

    int n_cmp = 0;
    int n_bad = 0;
    int fv_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fsq_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_operand(issue_operand), .issue_rmode(issue_rmode),
        .issue_guard(issue_guard), .issue_flags_only(issue_flags_only),
        .busy(busy), .res_we(res_we), .res_data(res_data),
        .flags_valid(flags_valid), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .flag_in_ftz(flag_in_ftz),
        .flag_out_ftz(flag_out_ftz)
    );

    always @(negedge clk) if (flags_valid) fv_seen++;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bench model: returns word, flags {inv,inx,ifz,ofz} and requirement tag
    function automatic void model(input logic [31:0] op, input logic [1:0] rm,
                                  output logic [31:0] w, output logic [3:0] fl,
                                  output string tag);
        logic s;
        logic [7:0] e;
        logic [22:0] f;
        int ue;
        int half;
        longint unsigned r48;
        longint unsigned q;
        longint unsigned sig;
        logic g;
        logic st;
        logic up;
        int ex;
        s = op[31]; e = op[30:23]; f = op[22:0];
        fl = 4'b0000;
        if (e == 8'd0) begin
            w = {s, 31'd0}; fl[1] = (f != 0); tag = (f != 0) ? "R4" : "R5"; return;
        end
        if (e == 8'hFF && f != 0) begin
            w = 32'hFFFF_FFFF; fl[3] = !f[22]; tag = "R7"; return;
        end
        if (s) begin
            w = 32'hFFFF_FFFF; fl[3] = 1'b1; tag = "R6"; return;
        end
        if (e == 8'hFF) begin
            w = 32'h7F80_0000; tag = "R8"; return;
        end
        ue   = int'(e) - 127;
        half = ue >>> 1;
        r48  = longint'({1'b1, f}) << (((ue & 1) != 0) ? 26 : 25);
        q = 0;
        for (int b = 25; b >= 0; b--) begin
            longint unsigned cand;
            cand = q | (64'd1 << b);
            if (cand * cand <= r48) q = cand;
        end
        sig = q >> 1;
        g   = q[0];
        st  = (q * q != r48);
        case (rm)
            2'b00:   up = g & (st | sig[0]);
            2'b10:   up = g | st;
            default: up = 1'b0;
        endcase
        sig = sig + longint'(up);
        ex  = half + 127;
        if (sig == (64'd1 << 24)) begin
            sig = sig >> 1;
            ex  = ex + 1;
        end
        w = {1'b0, 8'(ex), sig[22:0]};
        fl[2] = g | st;
        tag = (rm != 2'b00) ? "R2" : ((g | st) ? "R1" : "R3");
    endfunction

    // Issue one operation and check its report at the 17th edge
    task automatic run_op(input logic [31:0] op, input logic [1:0] rm,
                          input logic g, input logic fo);
        logic [31:0] ew;
        logic [3:0]  ef;
        string       tag;
        model(op, rm, ew, ef, tag);
        while (busy) @(negedge clk);
        issue_operand = op; issue_rmode = rm;
        issue_guard = g; issue_flags_only = fo; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        repeat (16) @(negedge clk);
        check("R9", "early report", {31'd0, flags_valid}, 32'd0);
        @(negedge clk);
        if (!g) begin
            check("R11", "guarded write", {31'd0, res_we}, 32'd0);
            check("R11", "guarded report", {31'd0, flags_valid}, 32'd0);
            check("R11", "guarded flags",
                  {28'd0, flag_invalid, flag_inexact, flag_in_ftz, flag_out_ftz}, 32'd0);
        end else begin
            check("R9", "report strobe", {31'd0, flags_valid}, 32'd1);
            check(tag, "flags",
                  {28'd0, flag_invalid, flag_inexact, flag_in_ftz, flag_out_ftz},
                  {28'd0, ef});
            check("R13", "output flush", {31'd0, flag_out_ftz}, 32'd0);
            if (fo) begin
                check("R12", "query write", {31'd0, res_we}, 32'd0);
            end else begin
                check("R9", "write strobe", {31'd0, res_we}, 32'd1);
                check(tag, "result", res_data, ew);
            end
        end
        @(negedge clk);
        check("R9", "strobe width", {31'd0, flags_valid}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] op;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R9", "reset report", {31'd0, flags_valid}, 32'd0);
        check("R9", "reset write", {31'd0, res_we}, 32'd0);
        check("R10", "reset busy", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reference vectors
        run_op(32'h4040_0000, 2'b00, 1'b1, 1'b0);
        check("R1", "3.0 root", res_data, 32'h3FDD_B3D7);
        run_op(32'h00C0_0000, 2'b00, 1'b1, 1'b0);
        check("R1", "min-range root", res_data, 32'h201C_C471);
        run_op(32'h7F7F_FFFF, 2'b00, 1'b1, 1'b0);
        check("R1", "max-normal root", res_data, 32'h5F7F_FFFF);
        // R3 exact squares
        run_op(32'h4080_0000, 2'b00, 1'b1, 1'b0);
        check("R3", "4.0 root", res_data, 32'h4000_0000);
        run_op(32'h4010_0000, 2'b01, 1'b1, 1'b0);
        run_op(32'h3E80_0000, 2'b10, 1'b1, 1'b0);
        run_op(32'h3F80_0000, 2'b11, 1'b1, 1'b0);
        // R2 each direction on an inexact root, including a carry case
        for (int m = 0; m < 4; m++) begin
            run_op(32'h4040_0000, 2'(m), 1'b1, 1'b0);
            run_op(32'h7F7F_FFFF, 2'(m), 1'b1, 1'b0);
        end
        // R4 / R5 / R6 / R7 / R8 special paths
        run_op(32'h0040_0000, 2'b00, 1'b1, 1'b0);
        check("R4", "denormal root", res_data, 32'h0000_0000);
        run_op(32'h8000_0001, 2'b00, 1'b1, 1'b0);
        run_op(32'h0000_0000, 2'b00, 1'b1, 1'b0);
        run_op(32'h8000_0000, 2'b10, 1'b1, 1'b0);
        check("R5", "negative zero", res_data, 32'h8000_0000);
        run_op(32'hC040_0000, 2'b00, 1'b1, 1'b0);
        check("R6", "-3.0 root", res_data, 32'hFFFF_FFFF);
        run_op(32'hFF80_0000, 2'b00, 1'b1, 1'b0);
        run_op(32'h7FC0_0000, 2'b00, 1'b1, 1'b0);
        run_op(32'hFFA0_0001, 2'b00, 1'b1, 1'b0);
        run_op(32'h7F80_0000, 2'b01, 1'b1, 1'b0);
        // R11 guard off, R12 query mode
        run_op(32'hC040_0000, 2'b00, 1'b0, 1'b0);
        run_op(32'h4040_0000, 2'b00, 1'b1, 1'b1);
        run_op(32'h0040_0000, 2'b00, 1'b1, 1'b1);

        // R10 dropped issue inside the window, accepted issue at its end
        while (busy) @(negedge clk);
        @(negedge clk);
        fv_seen = 0;
        issue_operand = 32'h4040_0000; issue_rmode = 2'b00;
        issue_guard = 1'b1; issue_flags_only = 1'b0; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R10", "busy in window", {31'd0, busy}, 32'd1);
        issue_operand = 32'h4080_0000; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R10", "busy at window end", {31'd0, busy}, 32'd0);
        issue_operand = 32'h4010_0000; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        @(negedge clk);
        check("R10", "first result", res_data, 32'h3FDD_B3D7);
        repeat (16) @(negedge clk);
        check("R10", "second accepted result", res_data, 32'h3FC0_0000);
        repeat (3) @(negedge clk);
        check("R10", "report count", 32'(fv_seen), 32'd2);

        // Seeded random operands
        for (int i = 0; i < 400; i++) begin
            logic [1:0] rm;
            logic g;
            logic fo;
            case ($urandom_range(0, 4))
                0: op = $urandom();
                1: op = {1'b0, 8'($urandom_range(1, 254)), 23'($urandom())};
                2: op = {1'b0, ($urandom_range(0, 1) != 0) ? 8'($urandom_range(1, 3))
                                                           : 8'($urandom_range(252, 254)),
                         23'($urandom())};
                3: op = {1'($urandom()), 8'd0, 23'($urandom())};
                default: op = {1'($urandom()), 8'hFF,
                               ($urandom_range(0, 1) != 0) ? 23'd0 : 23'($urandom())};
            endcase
            rm = 2'($urandom_range(0, 3));
            g  = ($urandom_range(0, 9) != 0);
            fo = ($urandom_range(0, 9) == 0);
            run_op(op, rm, g, fo);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule